// File: doc/BRIEF.md
# Indexed-Port BCD Real-Time Clock

This block is a calendar clock peripheral that a host reaches through two byte-wide ports on a simple strobed bus. The host selects a register by writing its index to the address port (port select 0). It then reads or writes that register through the data port (port select 1). The index stays latched, so repeated data-port accesses hit the same register. A one-second tick input advances packed-BCD seconds, minutes, hours, day of week, date, month and year, using a 24-hour clock and a two-digit year.

Each tick first raises an update-in-progress flag. The flag stays up for a fixed number of system clocks, then the carry chain is applied and the flag drops. A host that reads the flag as 0 can read the time fields safely. A freeze bit in control register B stops the counters and opens the time fields to host writes, so a new time can be loaded in one step. A battery-style user RAM and four control registers share the same index space. Data-port reads are registered: the value appears on `bus_rdata_o` one clock after the read strobe.

Top module: `rtc_idx_port`

## Requirements
- R1: A write with port select 0 latches the 8-bit index. A read with port select 0 returns the latched index on the next clock.
- R2: With port select 1, indices 0x00, 0x02, 0x04, 0x06, 0x07, 0x08 and 0x09 read seconds, minutes, hours, day of week, date, month and year. Indices 0x01, 0x03 and 0x05 are plain read/write byte storage for the alarm fields. After reset the time reads 00:00:00, with day of week 01, date 01, month 01 and year 00.
- R3: Bit 7 of control register B (index 0x0B) is the freeze bit; B holds all 8 bits written and resets to 0x02. While freeze is 1 the time fields accept host writes and do not advance. Host writes to time fields while freeze is 0 are ignored. After freeze is cleared, counting resumes from the loaded values.
- R4: Bit 7 of control register A (index 0x0A) is the update flag, and host writes to it are ignored. A tick raises it on the next clock. It reads 1 for UIP_LEAD clocks (default 4), and the increment takes effect on the clock where it falls. The time fields never change while the flag is 0, except through host loads under freeze.
- R5: Control register A bits 6:0 are read/write storage that reset to 0. Writing 0x2F reads back 0x2F while no update is running.
- R6: Control register C (0x0C) always reads 0x00 and D (0x0D) always reads 0x80; writes to either have no effect.
- R7: Indices 0x10 to 0x3F are 48 bytes of user RAM. Every byte written reads back unchanged.
- R8: A tick carries 59 seconds into minutes, 59 minutes into hours, and hour 23 into the next date; 23:59:59 becomes 00:00:00.
- R9: The date wraps to 01 after the month's last day: 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for 04, 06, 09 and 11. February has 29 days when the BCD year's value is a multiple of four, otherwise 28. Month 12 wraps to 01, and year 99 wraps to 00.
- R10: Day of week advances with the date, from 01 to 07, and 07 wraps to 01.
- R11: A tick is discarded, not queued, in three cases: freeze is 1, an update is already running, or freeze is set in the same clock as the tick. In none of these cases does any time field change.
- R12: Indices 0x0E, 0x0F and anything above 0x3F read 0x00. Writes to indices above 0x3F change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second tick pulse, one clock wide |
| bus_sel_i | input | 1 | Bus access strobe, one access per clock |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_port_i | input | 1 | 0 = address port, 1 = data port |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the clock after a read strobe |

## Verification
Two events can land on the same clock edge: a tick arriving, and a host write that sets the freeze bit. The bench latches index 0x0B beforehand, then drives the tick and the data write of 0x8A on the same clock. It then clears freeze and reads the seconds field, which must be unchanged. The bench also stacks a second tick inside a running update window and checks that the seconds advance by exactly one. During the update window it reads control register A on every clock, to confirm exactly when the flag rises and falls.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam logic [7:0] IX_SEC   = 8'h00;
    localparam logic [7:0] IX_ALM_S = 8'h01;
    localparam logic [7:0] IX_MIN   = 8'h02;
    localparam logic [7:0] IX_ALM_M = 8'h03;
    localparam logic [7:0] IX_HOUR  = 8'h04;
    localparam logic [7:0] IX_ALM_H = 8'h05;
    localparam logic [7:0] IX_DOW   = 8'h06;
    localparam logic [7:0] IX_DATE  = 8'h07;
    localparam logic [7:0] IX_MON   = 8'h08;
    localparam logic [7:0] IX_YEAR  = 8'h09;
    localparam logic [7:0] IX_CTLA  = 8'h0A;
    localparam logic [7:0] IX_CTLB  = 8'h0B;
    localparam logic [7:0] IX_CTLC  = 8'h0C;
    localparam logic [7:0] IX_CTLD  = 8'h0D;

    localparam logic [7:0] CTLB_RST = 8'h02;
    localparam logic [7:0] CTLD_VAL = 8'h80;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    typedef struct packed {
        logic [7:0] idx;
        logic [6:0] ctla;
        logic [7:0] ctlb;
        logic [7:0] alm_s;
        logic [7:0] alm_m;
        logic [7:0] alm_h;
        logic [7:0] rdata;
    } host_state_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Multiple of four: even tens with ones 0/4/8, odd tens with ones 2/6.
    function automatic logic bcd_leap(input logic [7:0] y);
        if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t advance(input rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.sec != 8'h59) n.sec = bcd_inc(t.sec);
        else begin
            n.sec = 8'h00;
            if (t.min != 8'h59) n.min = bcd_inc(t.min);
            else begin
                n.min = 8'h00;
                if (t.hour != 8'h23) n.hour = bcd_inc(t.hour);
                else begin
                    n.hour = 8'h00;
                    n.dow  = (t.dow >= 8'h07) ? 8'h01 : bcd_inc(t.dow);
                    if (t.date != month_last(t.mon, t.year)) n.date = bcd_inc(t.date);
                    else begin
                        n.date = 8'h01;
                        if (t.mon != 8'h12) n.mon = bcd_inc(t.mon);
                        else begin
                            n.mon  = 8'h01;
                            n.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter int UIP_LEAD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       freeze_i,
    input  logic       ld_en_i,
    input  logic [7:0] ld_idx_i,
    input  logic [7:0] ld_data_i,
    output rtc_time_t  time_o,
    output logic       uip_o
);

    localparam int CNT_W = (UIP_LEAD > 1) ? $clog2(UIP_LEAD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UIP_LEAD - 1);

    typedef struct packed {
        rtc_time_t        tm;
        logic             uip;
        logic [CNT_W-1:0] cnt;
    } tk_state_t;

    tk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (freeze_i) begin
            st_d.uip = 1'b0;
            st_d.cnt = '0;
            if (ld_en_i) begin
                case (ld_idx_i)
                    IX_SEC:  st_d.tm.sec  = ld_data_i;
                    IX_MIN:  st_d.tm.min  = ld_data_i;
                    IX_HOUR: st_d.tm.hour = ld_data_i;
                    IX_DOW:  st_d.tm.dow  = ld_data_i;
                    IX_DATE: st_d.tm.date = ld_data_i;
                    IX_MON:  st_d.tm.mon  = ld_data_i;
                    IX_YEAR: st_d.tm.year = ld_data_i;
                    default: ;
                endcase
            end
        end else if (st_q.uip) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.tm  = advance(st_q.tm);
                st_d.uip = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (tick_i) begin
            st_d.uip = 1'b1;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tm.sec  <= 8'h00;
            st_q.tm.min  <= 8'h00;
            st_q.tm.hour <= 8'h00;
            st_q.tm.dow  <= 8'h01;
            st_q.tm.date <= 8'h01;
            st_q.tm.mon  <= 8'h01;
            st_q.tm.year <= 8'h00;
            st_q.uip     <= 1'b0;
            st_q.cnt     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_o = st_q.tm;
    assign uip_o  = st_q.uip;

endmodule

// File: rtl/rtc_user_ram.sv
module rtc_user_ram #(
    parameter int DEPTH = 48,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o
);

    logic [7:0]       mem_d [DEPTH];
    logic [7:0]       mem_q [DEPTH];
    logic [DEPTH-1:0] we_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign we_vec[g] = we_i && (addr_i == AW'(g));
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = we_vec[i] ? wdata_i : mem_q[i];
        end
        rdata_o = (int'(addr_i) < DEPTH) ? mem_q[addr_i] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

endmodule

// File: rtl/rtc_idx_port.sv
module rtc_idx_port
    import rtc_pkg::*;
#(
    parameter int         UIP_LEAD  = 4,
    parameter int         RAM_DEPTH = 48,
    parameter logic [7:0] RAM_BASE  = 8'h10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       bus_sel_i,
    input  logic       bus_wr_i,
    input  logic       bus_port_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o
);

    localparam int RAM_AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

    host_state_t st_d, st_q;

    logic        wr_addr, wr_data, rd_strobe;
    logic        freeze, ld_fire, time_hit, ram_hit, tk_uip;
    logic [7:0]  ram_off, ram_rd, rd_val;
    rtc_time_t   tm;

    assign wr_addr   = bus_sel_i && bus_wr_i && !bus_port_i;
    assign wr_data   = bus_sel_i && bus_wr_i && bus_port_i;
    assign rd_strobe = bus_sel_i && !bus_wr_i && bus_port_i;
    assign freeze    = st_q.ctlb[7];
    assign time_hit  = st_q.idx inside {IX_SEC, IX_MIN, IX_HOUR, IX_DOW, IX_DATE, IX_MON, IX_YEAR};
    assign ld_fire   = wr_data && time_hit && freeze;
    assign ram_off   = st_q.idx - RAM_BASE;
    assign ram_hit   = ram_off < 8'(RAM_DEPTH);

    rtc_timekeeper #(.UIP_LEAD(UIP_LEAD)) u_tk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .freeze_i (freeze),
        .ld_en_i  (ld_fire),
        .ld_idx_i (st_q.idx),
        .ld_data_i(bus_wdata_i),
        .time_o   (tm),
        .uip_o    (tk_uip)
    );

    rtc_user_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (wr_data && ram_hit),
        .addr_i (ram_off[RAM_AW-1:0]),
        .wdata_i(bus_wdata_i),
        .rdata_o(ram_rd)
    );

    always_comb begin
        case (st_q.idx)
            IX_SEC:   rd_val = tm.sec;
            IX_ALM_S: rd_val = st_q.alm_s;
            IX_MIN:   rd_val = tm.min;
            IX_ALM_M: rd_val = st_q.alm_m;
            IX_HOUR:  rd_val = tm.hour;
            IX_ALM_H: rd_val = st_q.alm_h;
            IX_DOW:   rd_val = tm.dow;
            IX_DATE:  rd_val = tm.date;
            IX_MON:   rd_val = tm.mon;
            IX_YEAR:  rd_val = tm.year;
            IX_CTLA:  rd_val = {tk_uip, st_q.ctla};
            IX_CTLB:  rd_val = st_q.ctlb;
            IX_CTLC:  rd_val = 8'h00;
            IX_CTLD:  rd_val = CTLD_VAL;
            default:  rd_val = ram_hit ? ram_rd : 8'h00;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_addr) st_d.idx = bus_wdata_i;
        if (wr_data) begin
            case (st_q.idx)
                IX_ALM_S: st_d.alm_s = bus_wdata_i;
                IX_ALM_M: st_d.alm_m = bus_wdata_i;
                IX_ALM_H: st_d.alm_h = bus_wdata_i;
                IX_CTLA:  st_d.ctla  = bus_wdata_i[6:0];
                IX_CTLB:  st_d.ctlb  = bus_wdata_i;
                default: ;
            endcase
        end
        if (bus_sel_i && !bus_wr_i) st_d.rdata = bus_port_i ? rd_val : st_q.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idx   <= 8'h00;
            st_q.ctla  <= 7'h00;
            st_q.ctlb  <= CTLB_RST;
            st_q.alm_s <= 8'h00;
            st_q.alm_m <= 8'h00;
            st_q.alm_h <= 8'h00;
            st_q.rdata <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;

endmodule

// File: rtl/rtc_idx_port_chk.sv
module rtc_idx_port_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       uip,
    input logic       freeze,
    input logic       ld_fire,
    input rtc_time_t  tm,
    input logic       rd_strobe,
    input logic [7:0] idx,
    input logic [7:0] rdata
);

    assert_time_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip && !ld_fire) |=> $stable(tm));

    assert_freeze_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !uip);

    assert_sec_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(uip) && !$past(freeze) && $past(tm.sec) == 8'h59) |-> tm.sec == 8'h00);

    assert_dow_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(uip) && !$past(freeze) && $past(tm.dow) == 8'h07 && $past(tm.sec) == 8'h59
         && $past(tm.min) == 8'h59 && $past(tm.hour) == 8'h23) |-> tm.dow == 8'h01);

    assert_ctld_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && idx == 8'h0D) |=> rdata == 8'h80);

    assert_high_idx_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && idx >= 8'h40) |=> rdata == 8'h00);

endmodule

bind rtc_idx_port rtc_idx_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .uip      (tk_uip),
    .freeze   (freeze),
    .ld_fire  (ld_fire),
    .tm       (tm),
    .rd_strobe(rd_strobe),
    .idx      (st_q.idx),
    .rdata    (bus_rdata_o)
);

// File: tb/rtc_idx_port_test.sv
`timescale 1ns/1ps
module rtc_idx_port_test;

    localparam int LEAD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       bus_sel_i = 1'b0;
    logic       bus_wr_i = 1'b0;
    logic       bus_port_i = 1'b0;
    logic [7:0] bus_wdata_i = 8'h00;
    logic [7:0] bus_rdata_o;

    int compared = 0;
    int mismatched = 0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    rtc_idx_port #(.UIP_LEAD(LEAD)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_port_i(bus_port_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o)
    );

    always @(posedge clk) rd_seen <= bus_sel_i & ~bus_wr_i;

    // Monitor: every read strobe yields one result on the following clock.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen) begin
                if (exp_q.size() == 0) begin
                    mismatched++;
                    $display("FAIL unexpected read: actual %02h expected none", bus_rdata_o);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    compared++;
                    if (bus_rdata_o !== e) begin
                        mismatched++;
                        $display("FAIL %s: actual %02h expected %02h", t, bus_rdata_o, e);
                    end
                end
            end
        end
    end

    task automatic bus(input logic s, input logic w, input logic p, input logic [7:0] d);
        bus_sel_i = s; bus_wr_i = w; bus_port_i = p; bus_wdata_i = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus(1'b1, 1'b0, 1'b1, 8'h00);
    endtask

    task automatic wr_reg(input logic [7:0] ix, input logic [7:0] v);
        bus(1'b1, 1'b1, 1'b0, ix);
        bus(1'b1, 1'b1, 1'b1, v);
    endtask

    task automatic rd_reg(input logic [7:0] ix, input logic [7:0] e, input string t);
        bus(1'b1, 1'b1, 1'b0, ix);
        expect_rd(e, t);
    endtask

    task automatic tick();
        tick_i = 1'b1;
        idle(1);
        tick_i = 1'b0;
        idle(LEAD + 3);
    endtask

    task automatic load_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                             input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        wr_reg(8'h0B, 8'h8A);
        wr_reg(8'h09, y);
        wr_reg(8'h08, mo);
        wr_reg(8'h07, d);
        wr_reg(8'h04, h);
        wr_reg(8'h02, mi);
        wr_reg(8'h00, s);
        wr_reg(8'h0B, 8'h0A);
        idle(1);
    endtask

    task automatic roll_check(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                              input logic [7:0] emo, input logic [7:0] ed, input string t);
        load_time(y, mo, d, 8'h23, 8'h59, 8'h59);
        tick();
        rd_reg(8'h07, ed, t);
        rd_reg(8'h08, emo, t);
        idle(1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R2, R3, R5, R6)
        rd_reg(8'h00, 8'h00, "R2 reset sec");
        rd_reg(8'h04, 8'h00, "R2 reset hour");
        rd_reg(8'h06, 8'h01, "R2 reset dow");
        rd_reg(8'h07, 8'h01, "R2 reset date");
        rd_reg(8'h08, 8'h01, "R2 reset month");
        rd_reg(8'h0B, 8'h02, "R3 reset ctlb");
        rd_reg(8'h0A, 8'h00, "R5 reset ctla");
        rd_reg(8'h0D, 8'h80, "R6 reset ctld");

        // R1: address port read-back
        bus(1'b1, 1'b1, 1'b0, 8'h25);
        exp_q.push_back(8'h25); tag_q.push_back("R1 index readback");
        bus(1'b1, 1'b0, 1'b0, 8'h00);

        // R3: time write ignored while freeze clear
        wr_reg(8'h00, 8'h30);
        rd_reg(8'h00, 8'h00, "R3 write ignored unfrozen");

        // R3: load under freeze, ticks discarded (R11), resume
        wr_reg(8'h0B, 8'h8A);
        wr_reg(8'h00, 8'h58); wr_reg(8'h02, 8'h59); wr_reg(8'h04, 8'h23);
        wr_reg(8'h06, 8'h07); wr_reg(8'h07, 8'h31); wr_reg(8'h08, 8'h12);
        wr_reg(8'h09, 8'h99);
        rd_reg(8'h00, 8'h58, "R3 loaded sec");
        rd_reg(8'h02, 8'h59, "R2 loaded min");
        rd_reg(8'h09, 8'h99, "R2 loaded year");
        rd_reg(8'h0B, 8'h8A, "R3 ctlb freeze");
        idle(1);
        tick();
        rd_reg(8'h00, 8'h58, "R11 tick while frozen");
        wr_reg(8'h0B, 8'h0A);
        rd_reg(8'h0B, 8'h0A, "R3 ctlb cleared");
        idle(1);
        tick();
        rd_reg(8'h00, 8'h59, "R3 resumes from loaded");
        idle(1);
        tick();
        rd_reg(8'h00, 8'h00, "R8 sec wrap");
        rd_reg(8'h02, 8'h00, "R8 min wrap");
        rd_reg(8'h04, 8'h00, "R8 hour wrap");
        rd_reg(8'h06, 8'h01, "R10 dow 7 to 1");
        rd_reg(8'h07, 8'h01, "R9 date wrap dec");
        rd_reg(8'h08, 8'h01, "R9 month 12 to 1");
        rd_reg(8'h09, 8'h00, "R9 year 99 to 00");
        idle(1);
        tick();
        rd_reg(8'h06, 8'h01, "R10 dow holds within day");
        idle(1);

        // R9: month lengths and leap years
        roll_check(8'h24, 8'h02, 8'h28, 8'h02, 8'h29, "R9 leap 24 feb28");
        roll_check(8'h24, 8'h02, 8'h29, 8'h03, 8'h01, "R9 leap 24 feb29");
        roll_check(8'h25, 8'h02, 8'h28, 8'h03, 8'h01, "R9 nonleap 25");
        roll_check(8'h00, 8'h02, 8'h28, 8'h02, 8'h29, "R9 leap 00");
        roll_check(8'h12, 8'h02, 8'h28, 8'h02, 8'h29, "R9 leap 12");
        roll_check(8'h14, 8'h02, 8'h28, 8'h03, 8'h01, "R9 nonleap 14");
        roll_check(8'h23, 8'h04, 8'h30, 8'h05, 8'h01, "R9 april 30");
        roll_check(8'h23, 8'h11, 8'h30, 8'h12, 8'h01, "R9 nov 30");
        roll_check(8'h23, 8'h01, 8'h31, 8'h02, 8'h01, "R9 jan 31");
        roll_check(8'h23, 8'h07, 8'h30, 8'h07, 8'h31, "R9 jul 30");

        // R8: minute carry without hour carry
        load_time(8'h23, 8'h05, 8'h05, 8'h09, 8'h59, 8'h59);
        tick();
        rd_reg(8'h04, 8'h10, "R8 hour bcd carry");
        rd_reg(8'h02, 8'h00, "R8 min to 00");

        // R5 / R4: ctla storage and update flag timing
        load_time(8'h23, 8'h05, 8'h05, 8'h10, 8'h00, 8'h05);
        wr_reg(8'h0A, 8'hAF);
        rd_reg(8'h0A, 8'h2F, "R5 ctla readback, flag not writable");
        exp_q.push_back(8'h2F); tag_q.push_back("R4 flag before tick");
        tick_i = 1'b1;
        bus(1'b1, 1'b0, 1'b1, 8'h00);
        tick_i = 1'b0;
        for (int i = 0; i < LEAD; i++) expect_rd(8'hAF, "R4 flag high window");
        expect_rd(8'h2F, "R4 flag falls");
        rd_reg(8'h00, 8'h06, "R4 increment at fall");
        idle(1);

        // R11: tick inside running window discarded
        tick_i = 1'b1; idle(1); tick_i = 1'b0; idle(1);
        tick_i = 1'b1; idle(1); tick_i = 1'b0;
        idle(LEAD + 4);
        rd_reg(8'h00, 8'h07, "R11 overlapping tick");

        // R11: tick coincident with freeze write
        bus(1'b1, 1'b1, 1'b0, 8'h0B);
        tick_i = 1'b1;
        bus(1'b1, 1'b1, 1'b1, 8'h8A);
        tick_i = 1'b0;
        idle(LEAD + 4);
        wr_reg(8'h0B, 8'h0A);
        idle(LEAD + 4);
        rd_reg(8'h00, 8'h07, "R11 tick with freeze write");

        // R2: alarm storage
        wr_reg(8'h01, 8'h12); wr_reg(8'h03, 8'h34); wr_reg(8'h05, 8'h56);
        rd_reg(8'h01, 8'h12, "R2 alarm sec");
        rd_reg(8'h03, 8'h34, "R2 alarm min");
        rd_reg(8'h05, 8'h56, "R2 alarm hour");

        // R6: C and D fixed
        wr_reg(8'h0C, 8'hFF); wr_reg(8'h0D, 8'h00);
        rd_reg(8'h0C, 8'h00, "R6 ctlc");
        rd_reg(8'h0D, 8'h80, "R6 ctld");

        // R7: user RAM
        for (int i = 0; i < 48; i++) wr_reg(8'(16 + i), 8'((i * 7) ^ 8'hA5));
        for (int i = 0; i < 48; i++) rd_reg(8'(16 + i), 8'((i * 7) ^ 8'hA5), "R7 ram byte");

        // R12: unimplemented indices
        wr_reg(8'h40, 8'h77); wr_reg(8'hFF, 8'h77); wr_reg(8'h0E, 8'h77);
        rd_reg(8'h40, 8'h00, "R12 idx 40");
        rd_reg(8'hFF, 8'h00, "R12 idx FF");
        rd_reg(8'h0E, 8'h00, "R12 idx 0E");
        rd_reg(8'h10, 8'hA5, "R12 ram untouched");
        rd_reg(8'h3F, 8'((47 * 7) ^ 8'hA5), "R12 ram top untouched");
        rd_reg(8'h00, 8'h07, "R12 sec untouched");

        idle(4);
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL pending reads: actual %0d expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule